// File: doc/BRIEF.md
# Copy-Engine Channel Run Control

This block governs the run state of one channel of a descriptor-driven copy engine. A host writes a small control byte to ask the channel to pause, to halt, or to sit in reset, and to arm an automatic pause when a transfer fails. The block moves the channel through running, paused, halted and reset states and reports the paused and halted conditions as flags in a status word. Software polls these flags until they match what it asked for. Pause and halt requests take effect only once the engine reports no work in flight.

Reset is a level: the channel stays in reset for as long as the control byte holds the reset bit. When software releases it, the channel comes out halted, and the halt bit reads back as set. Software then clears only that bit with a read-modify-write. While pause-on-error is armed, a failed transfer sets one of seventeen sticky cause bits in the status word. It also sets the pause bit in the control byte, moves the channel to paused, and raises a one-cycle status interrupt. The lowest set cause bit is presented as the reported cause code. A separate configuration word carries the channel enable bit.

Top module: `chan_runctl`

## Requirements
- R1: Control byte fields are pause at bit 0, halt at bit 1, reset at bit 2 and pause-on-error arm at bit 3. A write stores bits 3:0. Bits 7:4 read as zero. The read-back value also shows bits that the hardware sets (R4, R5).
- R2: With the pause bit set and the halt bit clear, status bit 9 (paused) rises at the second clock edge after the write at the earliest, and only at an edge where `eng_busy` is low. Once the channel is paused, writing zero to the control byte clears status bit 9 at the second edge after the write.
- R3: With the halt bit set, status bit 10 (halted) rises at the first edge where `eng_busy` is low, and no earlier than the second edge after the write. Clearing the halt bit clears status bit 10 at the second edge after the write. The channel then goes to paused if the pause bit is set, and to running otherwise.
- R4: While the reset bit is held, the channel is in reset: status bits 9, 10 and 13 to 29 read zero and `run_ok` is low. At the edge after the reset bit is seen clear, the channel enters halted and the halt bit of the control byte is set. System reset leaves the control byte at 0x02, the channel halted and the configuration word zero.
- R5: An error event (`err_valid` with cause index `err_idx` from 0 to 16) that arrives while the arm bit is set sets status bit 13+`err_idx`. At the same edge it sets the control pause bit and moves the channel to paused, unless the channel is halted, in which case it stays halted.
- R6: An error event is ignored, with no cause bit, no interrupt and no state change, when the arm bit is clear, when `err_idx` is 17 or more, or while the channel is in reset or the reset bit is set.
- R7: Cause bits are sticky: they clear only in reset. `stat_irq` is high for one cycle, at the edge where an accepted error sets a cause bit that was clear. An accepted error whose bit is already set raises no interrupt.
- R8: `err_any` is high when any cause bit is set, and `err_code` gives the index of the lowest set cause bit.
- R9: The configuration word reads back what was last written. Bit 1 is the channel enable. `run_ok` is high exactly when the enable bit is set and the channel is running (neither paused, halted nor in reset).
- R10: When both the pause and halt bits are set, halt wins: the channel reports halted with status bit 9 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rd | output | 8 | Control byte read-back |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | CFG_W | Configuration word write data |
| cfg_rd | output | CFG_W | Configuration word read-back |
| status | output | STAT_W | Paused at bit 9, halted at bit 10, causes at bits 13..29 |
| eng_busy | input | 1 | Engine has work in flight (stub) |
| err_valid | input | 1 | Transfer failure event (stub) |
| err_idx | input | CIDX_W | Cause index of the failure |
| stat_irq | output | 1 | One-cycle channel status interrupt |
| err_code | output | CIDX_W | Index of the lowest latched cause |
| err_any | output | 1 | Some cause is latched |
| run_ok | output | 1 | Channel enabled and running |

## Verification
The hardest situations to reach are the overlaps. One is an error arriving while the channel is already paused or halted with the cause bit already set. Another is an error that lands inside the reset window. A third is a pause request held off by a busy engine. The stimulus arms pause-on-error and sends repeated and out-of-range cause indices back to back. It also sends an error pulse while the reset bit is held, and keeps `eng_busy` high for several cycles after a pause or halt write. A behavioural reference model compares every output on every cycle.

// File: rtl/chan_runctl_pkg.sv
package chan_runctl_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_PAUSED = 2'd1,
    ST_HALTED = 2'd2,
    ST_RESET  = 2'd3
  } chan_state_e;

  // control byte field positions, low nibble
  typedef struct packed {
    logic arm;    // bit 3
    logic reset;  // bit 2
    logic halt;   // bit 1
    logic pause;  // bit 0
  } ctrl_t;

  localparam int CTRL_FIELDS = 4;
endpackage

// File: rtl/chan_ctrl_reg.sv
module chan_ctrl_reg
  import chan_runctl_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_wdata,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             hw_set_halt,
  input  logic             hw_set_pause,
  output ctrl_t            ctrl_q,
  output logic [CFG_W-1:0] cfg_q
);
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = ctrl_t'(ctrl_wdata[CTRL_FIELDS-1:0]);
    if (hw_set_halt)  ctrl_d.halt  = 1'b1;
    if (hw_set_pause) ctrl_d.pause = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '{arm: 1'b0, reset: 1'b0, halt: 1'b1, pause: 1'b0};
      cfg_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (cfg_wr) cfg_q <= cfg_wdata;
    end
  end
endmodule

// File: rtl/chan_state_fsm.sv
module chan_state_fsm
  import chan_runctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctrl_t       ctrl_q,
  input  logic        eng_busy,
  input  logic        err_hit,
  output chan_state_e state_q,
  output logic        set_halt
);
  chan_state_e state_d;

  // leaving reset re-arms the halt bit in the control byte
  assign set_halt = (state_q == ST_RESET) && !ctrl_q.reset;

  always_comb begin
    state_d = state_q;
    if (ctrl_q.reset) begin
      state_d = ST_RESET;
    end else if (state_q == ST_RESET) begin
      state_d = ST_HALTED;
    end else if (ctrl_q.halt) begin
      if (state_q == ST_HALTED || !eng_busy) state_d = ST_HALTED;
      else if (err_hit)                       state_d = ST_PAUSED;
    end else if (err_hit) begin
      state_d = ST_PAUSED;
    end else if (ctrl_q.pause) begin
      if (state_q != ST_RUN || !eng_busy) state_d = ST_PAUSED;
    end else begin
      state_d = ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_HALTED;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/chan_cause_latch.sv
module chan_cause_latch #(
  parameter int NUM_CAUSE = 17,
  parameter int CIDX_W    = $clog2(NUM_CAUSE)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 err_hit,
  input  logic [CIDX_W-1:0]    err_idx,
  output logic [NUM_CAUSE-1:0] cause_q,
  output logic                 irq_q,
  output logic [CIDX_W-1:0]    code,
  output logic                 any
);
  logic [NUM_CAUSE-1:0] sel;

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
    assign sel[g] = (err_idx == CIDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst || clear)          cause_q[g] <= 1'b0;
      else if (err_hit && sel[g]) cause_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= err_hit && !clear && |(sel & ~cause_q);
  end

  always_comb begin
    code = '0;
    for (int i = NUM_CAUSE - 1; i >= 0; i--)
      if (cause_q[i]) code = CIDX_W'(i);
  end

  assign any = |cause_q;
endmodule

// File: rtl/chan_runctl.sv
module chan_runctl
  import chan_runctl_pkg::*;
#(
  parameter int CFG_W      = 32,
  parameter int STAT_W     = 32,
  parameter int NUM_CAUSE  = 17,
  parameter int CAUSE_LSB  = 13,
  parameter int PAUSED_BIT = 9,
  parameter int HALTED_BIT = 10,
  parameter int EN_BIT     = 1,
  parameter int CIDX_W     = $clog2(NUM_CAUSE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rd,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rd,
  output logic [STAT_W-1:0] status,
  input  logic              eng_busy,
  input  logic              err_valid,
  input  logic [CIDX_W-1:0] err_idx,
  output logic              stat_irq,
  output logic [CIDX_W-1:0] err_code,
  output logic              err_any,
  output logic              run_ok
);
  ctrl_t                ctrl_q;
  chan_state_e          state_q;
  logic                 set_halt;
  logic                 err_hit;
  logic [NUM_CAUSE-1:0] cause_q;

  assign err_hit = err_valid && ctrl_q.arm && !ctrl_q.reset &&
                   (state_q != ST_RESET) && (int'(err_idx) < NUM_CAUSE);

  chan_ctrl_reg #(.CFG_W(CFG_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .ctrl_wr     (ctrl_wr),
    .ctrl_wdata  (ctrl_wdata),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .hw_set_halt (set_halt),
    .hw_set_pause(err_hit),
    .ctrl_q      (ctrl_q),
    .cfg_q       (cfg_rd)
  );

  chan_state_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .ctrl_q  (ctrl_q),
    .eng_busy(eng_busy),
    .err_hit (err_hit),
    .state_q (state_q),
    .set_halt(set_halt)
  );

  chan_cause_latch #(.NUM_CAUSE(NUM_CAUSE), .CIDX_W(CIDX_W)) u_cause (
    .clk    (clk),
    .rst    (rst),
    .clear  (ctrl_q.reset),
    .err_hit(err_hit),
    .err_idx(err_idx),
    .cause_q(cause_q),
    .irq_q  (stat_irq),
    .code   (err_code),
    .any    (err_any)
  );

  assign ctrl_rd = {{(8 - CTRL_FIELDS){1'b0}}, ctrl_q};

  always_comb begin
    status = '0;
    status[PAUSED_BIT] = (state_q == ST_PAUSED);
    status[HALTED_BIT] = (state_q == ST_HALTED);
    status[CAUSE_LSB +: NUM_CAUSE] = cause_q;
  end

  assign run_ok = cfg_rd[EN_BIT] && (state_q == ST_RUN);
endmodule

// File: rtl/chan_runctl_chk.sv
module chan_runctl_chk #(
  parameter int CFG_W      = 32,
  parameter int STAT_W     = 32,
  parameter int NUM_CAUSE  = 17,
  parameter int CAUSE_LSB  = 13,
  parameter int PAUSED_BIT = 9,
  parameter int HALTED_BIT = 10,
  parameter int EN_BIT     = 1,
  parameter int CIDX_W     = $clog2(NUM_CAUSE)
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        ctrl_rd,
  input logic [CFG_W-1:0]  cfg_rd,
  input logic [STAT_W-1:0] status,
  input logic              stat_irq,
  input logic              err_any,
  input logic              run_ok
);
  logic [NUM_CAUSE-1:0] causes;
  assign causes = status[CAUSE_LSB +: NUM_CAUSE];

  // R4: a reset bit held over two samples means every flag and cause reads zero
  a_r4_reset_clears: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd[2] && $past(ctrl_rd[2])) |->
      (!status[PAUSED_BIT] && !status[HALTED_BIT] && causes == '0 && !run_ok));

  // R7: cause bits never fall unless the reset bit was set
  a_r7_sticky_causes: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_rd[2]) |-> ((causes & $past(causes)) == $past(causes)));

  // R5: an interrupt comes with a latched cause and a stopped channel
  a_r5_irq_with_cause: assert property (@(posedge clk) disable iff (rst)
    stat_irq |-> (causes != '0 && (status[PAUSED_BIT] || status[HALTED_BIT]) && ctrl_rd[0]));

  // R10: paused and halted never show together
  a_r10_exclusive_flags: assert property (@(posedge clk) disable iff (rst)
    !(status[PAUSED_BIT] && status[HALTED_BIT]));

  // R9: run permission only when enabled and not stopped
  a_r9_run_gate: assert property (@(posedge clk) disable iff (rst)
    run_ok |-> (cfg_rd[EN_BIT] && !status[PAUSED_BIT] && !status[HALTED_BIT]));

  // R8: summary flag tracks the cause field
  a_r8_any_flag: assert property (@(posedge clk) disable iff (rst)
    err_any == (causes != '0));

  // R1: upper control bits stay zero
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd[7:4] == 4'h0);
endmodule

bind chan_runctl chan_runctl_chk #(
  .CFG_W(CFG_W), .STAT_W(STAT_W), .NUM_CAUSE(NUM_CAUSE), .CAUSE_LSB(CAUSE_LSB),
  .PAUSED_BIT(PAUSED_BIT), .HALTED_BIT(HALTED_BIT), .EN_BIT(EN_BIT), .CIDX_W(CIDX_W)
) u_chk (
  .clk(clk), .rst(rst), .ctrl_rd(ctrl_rd), .cfg_rd(cfg_rd), .status(status),
  .stat_irq(stat_irq), .err_any(err_any), .run_ok(run_ok)
);

// File: tb/chan_runctl_tb.sv
module chan_runctl_tb;
  localparam int CW = 32;
  localparam int SW = 32;
  localparam int NC = 17;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctrl_wr = 1'b0;
  logic [7:0]    ctrl_wdata = '0;
  logic [7:0]    ctrl_rd;
  logic          cfg_wr = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [CW-1:0] cfg_rd;
  logic [SW-1:0] status;
  logic          eng_busy = 1'b0;
  logic          err_valid = 1'b0;
  logic [IW-1:0] err_idx = '0;
  logic          stat_irq;
  logic [IW-1:0] err_code;
  logic          err_any;
  logic          run_ok;

  always #5 clk = ~clk;

  chan_runctl u_dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .status(status),
    .eng_busy(eng_busy), .err_valid(err_valid), .err_idx(err_idx), .stat_irq(stat_irq),
    .err_code(err_code), .err_any(err_any), .run_ok(run_ok)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 run, 1 paused, 2 halted, 3 reset
  int       m_state = 2;
  int       m_ctrl = 2;
  longint   m_cfg = 0;
  bit [NC-1:0] m_cause = '0;
  bit       m_irq = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 2; m_ctrl = 2; m_cfg = 0; m_cause = '0; m_irq = 0;
    end else begin
      bit pz, hl, rs, ar, hit, fresh;
      int ns, nc;
      pz = m_ctrl[0]; hl = m_ctrl[1]; rs = m_ctrl[2]; ar = m_ctrl[3];
      hit = err_valid && ar && !rs && m_state != 3 && int'(err_idx) < NC;
      fresh = hit && !m_cause[err_idx];
      ns = m_state;
      if (rs) ns = 3;
      else if (m_state == 3) ns = 2;
      else if (hl && (m_state == 2 || !eng_busy)) ns = 2;
      else if (hit) ns = 1;
      else if (hl) ns = m_state;
      else if (pz && (m_state != 0 || !eng_busy)) ns = 1;
      else if (pz) ns = 0;
      else ns = 0;
      nc = ctrl_wr ? int'(ctrl_wdata) & 15 : m_ctrl;
      if (m_state == 3 && !rs) nc = nc | 2;
      if (hit) nc = nc | 1;
      if (rs) m_cause = '0;
      else if (hit) m_cause[err_idx] = 1'b1;
      if (cfg_wr) m_cfg = longint'(cfg_wdata);
      m_irq = fresh;
      m_state = ns;
      m_ctrl = nc;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      int code;
      code = 0;
      for (int i = NC - 1; i >= 0; i--) if (m_cause[i]) code = i;
      chk("R1 ctrl readback", ctrl_rd, m_ctrl);
      chk("R2 paused flag", status[9], m_state == 1);
      chk("R3 halted flag", status[10], m_state == 2);
      chk("R5 cause field", status[29:13], m_cause);
      chk("R7 status irq", stat_irq, m_irq);
      chk("R8 err_code", m_cause != 0 ? err_code : 0, code);
      chk("R8 err_any", err_any, m_cause != 0);
      chk("R9 cfg readback", cfg_rd, m_cfg);
      chk("R9 run_ok", run_ok, (m_cfg & 2) != 0 && m_state == 0);
      chk("R4 other status bits zero", {status[31:30], status[12:11], status[8:0]}, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_cfg(input logic [CW-1:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic err_pulse(input int idx);
    err_valid = 1'b1; err_idx = IW'(idx);
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R4: power-on state
    chk("R4 reset ctrl", ctrl_rd, 8'h02);
    chk("R4 reset halted", status[10], 1);
    chk("R9 reset cfg", cfg_rd, 0);

    wr_cfg(32'h2);
    wr_ctrl(8'h00);               // read-modify-write of 0x02 without halt
    idle(1);
    chk("R3 unhalt", status[10], 0);
    chk("R9 run_ok enabled", run_ok, 1);

    // R2: pause held off by busy engine
    eng_busy = 1'b1;
    wr_ctrl(8'h01);
    idle(3);
    chk("R2 pause waits for drain", status[9], 0);
    eng_busy = 1'b0;
    idle(1);
    chk("R2 paused after drain", status[9], 1);
    wr_ctrl(8'h00);
    idle(1);
    chk("R2 resume clears paused", status[9], 0);

    // R3 / R10: halt and pause together
    eng_busy = 1'b1;
    wr_ctrl(8'h03);
    idle(2);
    chk("R3 halt waits for drain", status[10], 0);
    eng_busy = 1'b0;
    idle(1);
    chk("R10 halted", status[10], 1);
    chk("R10 paused low while halted", status[9], 0);
    wr_ctrl(8'h01);
    idle(1);
    chk("R3 leave halt to paused", status[9], 1);
    wr_ctrl(8'h00);
    idle(1);

    // R6: unarmed error ignored
    err_pulse(4);
    idle(1);
    chk("R6 unarmed ignored", status[29:13], 0);
    chk("R6 unarmed no pause", status[9], 0);

    // R5 / R7 / R8: armed errors
    wr_ctrl(8'h08);
    eng_busy = 1'b1;
    err_pulse(7);
    chk("R5 irq on new cause", stat_irq, 1);
    chk("R5 cause bit 20", status[20], 1);
    chk("R5 paused by error", status[9], 1);
    err_pulse(3);
    chk("R7 irq on second new cause", stat_irq, 1);
    err_pulse(3);
    chk("R7 no irq on repeat cause", stat_irq, 0);
    err_pulse(17);
    chk("R6 out of range ignored", stat_irq, 0);
    eng_busy = 1'b0;
    chk("R8 lowest cause code", err_code, 3);
    chk("R5 pause bit set by hardware", ctrl_rd, 8'h09);
    err_pulse(0);
    chk("R8 new lowest cause", err_code, 0);

    wr_ctrl(8'h08);
    idle(1);
    chk("R2 resume after error", status[9], 0);
    chk("R7 causes stay sticky", status[29:13], 17'h00089);

    // R4: held reset with an error inside it
    wr_ctrl(8'h0C);
    err_pulse(1);
    idle(3);
    chk("R4 reset clears status", status, 0);
    chk("R6 error in reset no irq", stat_irq, 0);
    wr_ctrl(8'h08);
    idle(1);
    chk("R4 out of reset halted", status[10], 1);
    chk("R4 halt bit re-set", ctrl_rd, 8'h0A);

    // R9: enable cleared blocks run_ok
    wr_cfg(32'hFFFF_FFFD);
    wr_ctrl(8'h08);
    idle(2);
    chk("R9 run_ok needs enable", run_ok, 0);
    wr_cfg(32'h0000_0002);
    idle(1);
    chk("R9 run_ok with enable", run_ok, 1);

    // halted channel taking an armed error stays halted
    wr_ctrl(8'h0A);
    idle(2);
    err_pulse(16);
    chk("R5 halted stays halted on error", status[10], 1);
    idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule